// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Model

This block is a synthesizable behavioural model of an asynchronous static RAM whose word is split into independently enabled byte lanes. It is built for a simulation or emulation fabric: the surrounding logic drives the same active-low strobes a board-level memory would see, and the model answers with read data and a per-lane drive indication. The bidirectional bus is replaced by a data-in port, a data-out port and a per-lane output-enable vector.

Reads are purely combinational. Whenever the part is selected, write is inactive and output enable is asserted, the stored word at the current address appears on the lanes whose byte enable is low. A write occupies the interval in which chip select and write strobe are both low. The write commits at the moment that interval closes, whichever of the two strobes rises first. Address, data and byte enables are all taken at that closing edge.

Depth, lane width and lane count are parameters. The defaults give a 16-bit word in two lanes over 1024 locations, and memory contents start out undefined.

Top module: `sram_bl_top`

## Requirements
- R1: The default word is 16 bits in two lanes: bits 7:0 belong to `be_n[0]` and bits 15:8 to `be_n[1]`, and a lane is enabled when its bit is 0.
- R2: While `ce_n` is 1, `dout_oe` is 2'b00 and `dout` is 0, whatever the other controls are.
- R3: With `ce_n`=0, `we_n`=1 and `oe_n`=0, each `dout_oe[i]` equals the inverse of `be_n[i]`, and each driven lane of `dout` carries that lane of the word stored at `addr`.
- R4: With `ce_n`=0 and `we_n`=1, either `oe_n`=1 or `be_n`=2'b11 gives `dout_oe`=2'b00.
- R5: While `ce_n` and `we_n` are both 0, `dout_oe` is 2'b00, even when `oe_n` is 0.
- R6: A write updates only the lanes whose byte enable is 0. A write with `be_n`=2'b11 changes nothing, and other addresses are never touched.
- R7: A write commits when the overlap of `ce_n`=0 and `we_n`=0 ends, by either strobe rising. The `addr` and `din` values present at that edge are the ones stored, and values seen earlier in the overlap are discarded.
- R8: The byte enables are sampled at the same closing edge as the data.
- R9: A lane whose `dout_oe` bit is 0 shows 0 on `dout`.
- R10: Read data follows a change of `addr` combinationally, without any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| be_n | input | LANES (2) | Per-lane byte enables, active low, bit 0 is the low lane |
| addr | input | ADDR_W (10) | Word address |
| din | input | LANES*LANE_W (16) | Write data |
| dout | output | LANES*LANE_W (16) | Read data, zero on undriven lanes |
| dout_oe | output | LANES (2) | Per-lane drive indication standing in for the tri-state bus |

## Verification
The assertions are immediate checks on the settled combinational outputs. They assume the strobes are 0 or 1 and never unknown, so the stimulus keeps every control at a defined level from time zero, with `ce_n` and `we_n` high and both byte enables off before the first access. Because the commit is an edge of the strobe overlap, the stimulus never moves `addr`, `din` or `be_n` in the same instant as the closing strobe. Every location is written before it is read.

// File: rtl/sram_bl_pkg.sv
package sram_bl_pkg;

   // Bus state seen by the lane drivers
   typedef enum logic [1:0] {
      BUS_DESEL = 2'd0,
      BUS_QUIET = 2'd1,
      BUS_READ  = 2'd2,
      BUS_WRITE = 2'd3
   } bus_mode_e;

   // Priority: deselect, then write, then output/byte gating
   function automatic bus_mode_e decode_mode(input logic ce_n, input logic we_n,
                                             input logic oe_n, input logic all_lanes_off);
      if (ce_n)
         return BUS_DESEL;
      else if (!we_n)
         return BUS_WRITE;
      else if (oe_n || all_lanes_off)
         return BUS_QUIET;
      else
         return BUS_READ;
   endfunction

endpackage

// File: rtl/sram_bl_ctrl.sv
module sram_bl_ctrl
   import sram_bl_pkg::*;
#(
   parameter int LANES = 2
) (
   input  logic             ce_n,
   input  logic             we_n,
   input  logic             oe_n,
   input  logic [LANES-1:0] be_n,
   output logic [LANES-1:0] lane_oe,
   output logic             wr_close
);

   bus_mode_e mode;

   always_comb begin
      mode = decode_mode(ce_n, we_n, oe_n, &be_n);
   end

   // A lane drives only in read mode and only when its enable is low
   always_comb begin
      lane_oe = '0;
      if (mode == BUS_READ)
         lane_oe = ~be_n;
   end

   // High whenever the select/write overlap is absent; its rising edge closes a write
   assign wr_close = ce_n | we_n;

endmodule

// File: rtl/sram_bl_array.sv
module sram_bl_array #(
   parameter int ADDR_W = 10,
   parameter int LANE_W = 8,
   parameter int LANES  = 2
) (
   input  logic                    wr_close,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] din,
   input  logic [LANES-1:0]        be_n,
   output logic [LANES*LANE_W-1:0] rd_word
);

   localparam int DEPTH = 1 << ADDR_W;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] store [DEPTH];

      // Address, data and enable are all taken at the edge ending the overlap
      always_ff @(posedge wr_close) begin
         if (!be_n[g])
            store[addr] <= din[g*LANE_W +: LANE_W];
      end

      assign rd_word[g*LANE_W +: LANE_W] = store[addr];
   end

endmodule

// File: rtl/sram_bl_rdmux.sv
module sram_bl_rdmux #(
   parameter int LANE_W = 8,
   parameter int LANES  = 2
) (
   input  logic [LANES*LANE_W-1:0] rd_word,
   input  logic [LANES-1:0]        lane_oe,
   output logic [LANES*LANE_W-1:0] dout
);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign dout[g*LANE_W +: LANE_W] = lane_oe[g] ? rd_word[g*LANE_W +: LANE_W] : '0;
   end

endmodule

// File: rtl/sram_bl_top.sv
module sram_bl_top #(
   parameter int ADDR_W = 10,
   parameter int LANE_W = 8,
   parameter int LANES  = 2
) (
   input  logic                    ce_n,
   input  logic                    we_n,
   input  logic                    oe_n,
   input  logic [LANES-1:0]        be_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic [LANES-1:0]        dout_oe
);

   localparam int WORD_W = LANES * LANE_W;

   if (ADDR_W < 1 || ADDR_W > 20) begin : g_bad_addr
      $error("ADDR_W out of range 1..20");
   end
   if (LANE_W < 1) begin : g_bad_lane
      $error("LANE_W must be positive");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be positive");
   end

   logic [LANES-1:0]  lane_oe;
   logic              wr_close;
   logic [WORD_W-1:0] rd_word;

   sram_bl_ctrl #(.LANES(LANES)) u_ctrl (
      .ce_n     (ce_n),
      .we_n     (we_n),
      .oe_n     (oe_n),
      .be_n     (be_n),
      .lane_oe  (lane_oe),
      .wr_close (wr_close)
   );

   sram_bl_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
      .wr_close (wr_close),
      .addr     (addr),
      .din      (din),
      .be_n     (be_n),
      .rd_word  (rd_word)
   );

   sram_bl_rdmux #(.LANE_W(LANE_W), .LANES(LANES)) u_rdmux (
      .rd_word (rd_word),
      .lane_oe (lane_oe),
      .dout    (dout)
   );

   assign dout_oe = lane_oe;

   always_comb begin
      AST_DESEL_QUIET: assert (!ce_n || (lane_oe == '0 && dout == '0)); // R2
      AST_WRITE_HIGHZ: assert (ce_n || we_n || lane_oe == '0); // R5
      AST_LANE_SUBSET: assert ((lane_oe & be_n) == '0); // R3
      AST_OUTOFF_QUIET: assert (ce_n || !we_n || !(oe_n || &be_n) || lane_oe == '0); // R4
   end

   for (genvar g = 0; g < LANES; g++) begin : g_chk
      always_comb begin
         AST_IDLE_LANE_ZERO: assert (lane_oe[g] || dout[g*LANE_W +: LANE_W] == '0); // R9
      end
   end

endmodule

// File: tb/tb_sram_bl_top.sv
module tb_sram_bl_top;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 10;
   localparam int NV = 14;
   localparam logic [1:0] OP_WWE = 2'd0;
   localparam logic [1:0] OP_WCE = 2'd1;
   localparam logic [1:0] OP_RD  = 2'd2;

   // {op[47:46], addr[45:36], be_n[35:34], data[33:18], exp_oe[17:16], exp_dout[15:0]}
   localparam logic [47:0] VEC [NV] = '{
      {OP_WWE, 10'h005, 2'b00, 16'hA1B2, 2'b00, 16'h0000},
      {OP_RD,  10'h005, 2'b00, 16'h0000, 2'b11, 16'hA1B2},
      {OP_RD,  10'h005, 2'b10, 16'h0000, 2'b01, 16'h00B2},
      {OP_RD,  10'h005, 2'b01, 16'h0000, 2'b10, 16'hA100},
      {OP_WWE, 10'h005, 2'b10, 16'h1234, 2'b00, 16'h0000},
      {OP_RD,  10'h005, 2'b00, 16'h0000, 2'b11, 16'hA134},
      {OP_WCE, 10'h3FF, 2'b00, 16'hC3D4, 2'b00, 16'h0000},
      {OP_WCE, 10'h3FF, 2'b01, 16'h5566, 2'b00, 16'h0000},
      {OP_RD,  10'h3FF, 2'b00, 16'h0000, 2'b11, 16'h55D4},
      {OP_WWE, 10'h005, 2'b11, 16'hFFFF, 2'b00, 16'h0000},
      {OP_RD,  10'h005, 2'b00, 16'h0000, 2'b11, 16'hA134},
      {OP_RD,  10'h005, 2'b11, 16'h0000, 2'b00, 16'h0000},
      {OP_WWE, 10'h000, 2'b00, 16'h0F0F, 2'b00, 16'h0000},
      {OP_RD,  10'h000, 2'b00, 16'h0000, 2'b11, 16'h0F0F}
   };

   logic          clk = 1'b0;
   logic          ce_n = 1'b1;
   logic          we_n = 1'b1;
   logic          oe_n = 1'b1;
   logic [1:0]    be_n = 2'b11;
   logic [AW-1:0] addr = '0;
   logic [15:0]   din = '0;
   logic [15:0]   dout;
   logic [1:0]    dout_oe;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   sram_bl_top #(.ADDR_W(AW), .LANE_W(8), .LANES(2)) dut (
      .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .be_n(be_n),
      .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   task automatic check(input string tag, input logic [1:0] exp_oe, input logic [15:0] exp_d);
      n_chk++;
      if (dout_oe !== exp_oe || dout !== exp_d) begin
         n_bad++;
         $display("FAIL %s: oe=%b dout=%h expected oe=%b dout=%h", tag, dout_oe, dout, exp_oe, exp_d);
      end
   endtask

   // Write ended by the write strobe rising
   task automatic wr_we(input logic [AW-1:0] a, input logic [1:0] be, input logic [15:0] d);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      addr = a; be_n = be; din = d;
      #2 ce_n = 1'b0;
      #2 we_n = 1'b0;
      #(CLK_PERIOD) we_n = 1'b1;
      #2 ce_n = 1'b1;
      #2;
   endtask

   // Write ended by chip select rising
   task automatic wr_ce(input logic [AW-1:0] a, input logic [1:0] be, input logic [15:0] d);
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      addr = a; be_n = be; din = d;
      #2 we_n = 1'b0;
      #2 ce_n = 1'b0;
      #(CLK_PERIOD) ce_n = 1'b1;
      #2 we_n = 1'b1;
      #2;
   endtask

   task automatic rd_set(input logic [AW-1:0] a, input logic [1:0] be);
      we_n = 1'b1; oe_n = 1'b0; ce_n = 1'b0;
      addr = a; be_n = be;
      #2;
   endtask

   task automatic park();
      ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; be_n = 2'b11;
      #2;
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            finish_run();
         end
      end
   end

   initial begin
      repeat (3) @(negedge clk);

      // R2: power-up, deselected with read-like controls
      oe_n = 1'b0; be_n = 2'b00; #2;
      check("R2 power-up deselect", 2'b00, 16'h0000);
      park();

      // R1 R3 R6 R9 table walk
      for (int i = 0; i < NV; i++) begin
         logic [47:0] v;
         v = VEC[i];
         case (v[47:46])
            OP_WWE: wr_we(v[45:36], v[35:34], v[33:18]);
            OP_WCE: wr_ce(v[45:36], v[35:34], v[33:18]);
            default: begin
               rd_set(v[45:36], v[35:34]);
               check($sformatf("R1 R3 R6 R9 vector %0d", i), v[17:16], v[15:0]);
               park();
            end
         endcase
      end

      // R2: stored data present, but chip deselected
      wr_we(10'h010, 2'b00, 16'h9ABC);
      rd_set(10'h010, 2'b00);
      check("R3 setup read", 2'b11, 16'h9ABC);
      ce_n = 1'b1; #2;
      check("R2 deselect with oe low", 2'b00, 16'h0000);

      // R4: output enable high
      ce_n = 1'b0; oe_n = 1'b1; #2;
      check("R4 oe_n high", 2'b00, 16'h0000);
      park();

      // R5: write overlap with output enable low
      din = 16'h9ABC; addr = 10'h010; be_n = 2'b00; oe_n = 1'b0;
      ce_n = 1'b0; #2 we_n = 1'b0; #2;
      check("R5 write hides outputs", 2'b00, 16'h0000);
      we_n = 1'b1; #2;
      check("R5 read after write", 2'b11, 16'h9ABC);
      park();

      // R7: data changed mid-overlap, last value kept
      wr_we(10'h020, 2'b00, 16'h0000);
      addr = 10'h020; be_n = 2'b00; din = 16'h1111;
      ce_n = 1'b0; #2 we_n = 1'b0; #2 din = 16'h2222; #2 we_n = 1'b1;
      #2 din = 16'h3333; oe_n = 1'b0; #2;
      check("R7 data at closing edge", 2'b11, 16'h2222);
      park();

      // R7: address changed mid-overlap, closed by chip select
      wr_we(10'h030, 2'b00, 16'h0000);
      wr_we(10'h031, 2'b00, 16'h0000);
      addr = 10'h030; be_n = 2'b00; din = 16'h4444;
      #2 we_n = 1'b0; #2 ce_n = 1'b0; #2 addr = 10'h031; #2 ce_n = 1'b1; #2 we_n = 1'b1; #2;
      rd_set(10'h030, 2'b00);
      check("R7 early address untouched", 2'b11, 16'h0000);
      rd_set(10'h031, 2'b00);
      check("R7 closing address written", 2'b11, 16'h4444);
      park();

      // R8: enables changed mid-overlap
      wr_we(10'h040, 2'b00, 16'hAAAA);
      addr = 10'h040; be_n = 2'b11; din = 16'h5555;
      ce_n = 1'b0; #2 we_n = 1'b0; #2 be_n = 2'b10; #2 we_n = 1'b1; #2 ce_n = 1'b1; #2;
      rd_set(10'h040, 2'b00);
      check("R8 enable raised to low lane", 2'b11, 16'hAA55);
      park();
      addr = 10'h040; be_n = 2'b00; din = 16'h6666;
      ce_n = 1'b0; #2 we_n = 1'b0; #2 be_n = 2'b11; #2 we_n = 1'b1; #2 ce_n = 1'b1; #2;
      rd_set(10'h040, 2'b00);
      check("R8 enables dropped before close", 2'b11, 16'hAA55);

      // R10: address change, no clock edge in between
      addr = 10'h031; #1;
      check("R10 combinational address follow", 2'b11, 16'h4444);
      addr = 10'h3FF; #1;
      check("R10 top address follow", 2'b11, 16'h55D4);
      park();

      done = 1'b1;
      finish_run();
   end

endmodule